// File: doc/BRIEF.md
# Byte-wide host to word-wide ATA register bridge

The bridge sits between an 8-bit I/O bus and a 16-bit ATA register interface. A 16-byte I/O window is decoded at a base chosen by a four-bit switch. Offsets 0 to 7 of the window reach the command block registers. Offsets 9 to 15 reach the control block registers. Offset 8 is a private byte-holding register that has no ATA cycle behind it. The holding register turns the word-wide ATA data register into two byte accesses. For a read, the host reads offset 0 first and then offset 8. For a write, the host writes offset 8 first and then offset 0.

The drive's interrupt line is steered to one host interrupt line, picked by a three-bit setting. A second four-bit switch places an 8 KB option-ROM select window in the upper memory area. All three settings are captured while reset is held and stay fixed afterwards. Every ATA access is a single-clock strobe. Read data passes through combinationally, and the holding register updates on the clock edge that ends the strobe.

Top module: `ata8_bridge`

## Requirements
- R1: An I/O access hits only when io_addr[9:4] equals bits [9:4] of 0x200 + 0x20*io_sw. A miss raises no chip select, no ATA strobe and no read data (host_rdata = 0), and it leaves the holding register unchanged.
- R2: A read at offset 0 raises ata_cs0, ata_rd and ata_wide with ata_addr = 0. host_rdata = ata_rdata[7:0], and the holding register takes ata_rdata[15:8] at the closing clock edge.
- R3: A read at offset 8 returns the holding register on host_rdata and raises no chip select or strobe.
- R4: A write at offset 8 loads host_wdata into the holding register and raises no chip select or strobe.
- R5: A write at offset 0 raises ata_cs0, ata_wr and ata_wide with ata_addr = 0, and drives ata_wdata = {holding register, host_wdata}.
- R6: Offsets 1 to 7 give byte accesses with ata_cs0 and ata_addr = offset[2:0]. ata_wide = 0, ata_wdata[15:8] = 0, host_rdata = ata_rdata[7:0], and the holding register is untouched.
- R7: Offsets 9 to 15 give byte accesses with ata_cs1 and ata_addr = offset[2:0]. ata_cs0 and ata_cs1 are never high together.
- R8: Read capture and write source use the same holding register, so a byte captured by an offset-0 read becomes the upper byte of a later offset-0 write.
- R9: host_irq[n] follows drive_irq when the captured setting n is 2, 3, 4, 5 or 7. Settings 0, 1 and 6 drive no line, and at most one line is ever high.
- R10: rom_sel is high exactly when mem_addr lies in [0xC0000 + 0x4000*rom_sw, that base + 0x2000).
- R11: io_sw, rom_sw and irq_sel are captured while rst_n is low. Changes to them after reset have no effect.
- R12: Reset clears the holding register, so an offset-8 read right after reset returns 0x00.
- R13: A cycle with iord and iowr both high is no access. It raises no strobe, returns 0 and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; switches are captured while low |
| io_sw | input | 4 | I/O window base switch |
| rom_sw | input | 4 | Option-ROM window base switch |
| irq_sel | input | 3 | Host interrupt line number |
| io_addr | input | 10 | Host I/O address |
| iord | input | 1 | Host I/O read strobe, one clock |
| iowr | input | 1 | Host I/O write strobe, one clock |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| mem_addr | input | 20 | Host memory address |
| rom_sel | output | 1 | Option-ROM select |
| ata_cs0 | output | 1 | Command block select |
| ata_cs1 | output | 1 | Control block select |
| ata_addr | output | 3 | ATA register address |
| ata_rd | output | 1 | ATA read strobe |
| ata_wr | output | 1 | ATA write strobe |
| ata_wide | output | 1 | Marks a 16-bit data register cycle |
| ata_wdata | output | 16 | ATA write data |
| ata_rdata | input | 16 | ATA read data |
| drive_irq | input | 1 | Drive interrupt request |
| host_irq | output | 8 | Host interrupt lines, index = line number |

## Verification
Some rules are checked by assertions on every cycle. The two selects are never high together, and a word cycle only ever targets register 0 of the command block. Offset 8 and missed addresses never strobe the drive, at most one host interrupt line is high, and no line is high without a drive request. The holding register loads only on its two triggers and otherwise holds. Other behaviour can only be shown by the bench's ordered scenarios. These include the byte pairing across two host cycles, a captured read byte reappearing in a later write, the exact window bases for given switch values, and switch changes after reset having no effect.

// File: rtl/ata8_bridge_pkg.sv
`timescale 1ns/1ps
package ata8_bridge_pkg;
  localparam int IO_AW     = 10;
  localparam int MEM_AW    = 20;
  localparam int SW_W      = 4;
  localparam int OFS_W     = 4;
  localparam int ROM_SPAN_W = 13;   // 8 KB select window

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_CMD   = 2'd1,
    TGT_CTL   = 2'd2,
    TGT_HOLD  = 2'd3
  } tgt_e;

  // I/O window base: 0x200 plus 0x20 per switch step
  function automatic logic [IO_AW-1:0] io_window_base(input logic [SW_W-1:0] sw);
    return IO_AW'(10'h200) + IO_AW'({sw, 5'b0});
  endfunction

  // ROM window base: 0xC0000 plus 16 KB per switch step
  function automatic logic [MEM_AW-1:0] rom_window_base(input logic [SW_W-1:0] sw);
    return MEM_AW'(20'hC0000) + MEM_AW'({sw, 14'b0});
  endfunction

  // Which target an in-window offset reaches
  function automatic tgt_e classify(input logic [OFS_W-1:0] ofs);
    if (ofs == 4'd8)      return TGT_HOLD;
    else if (ofs[3])      return TGT_CTL;
    else                  return TGT_CMD;
  endfunction
endpackage

// File: rtl/ata8_decode.sv
`timescale 1ns/1ps
module ata8_decode
  import ata8_bridge_pkg::*;
#(
  parameter int AW = IO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          iord,
  input  logic          iowr,
  input  logic [AW-1:0] win_base,
  output logic          acc_rd,
  output logic          acc_wr,
  output tgt_e          tgt,
  output logic [2:0]    reg_sel,
  output logic          word_cyc
);
  logic              win_hit;
  logic [OFS_W-1:0]  ofs;

  assign ofs      = io_addr[OFS_W-1:0];
  assign win_hit  = (io_addr[AW-1:OFS_W] == win_base[AW-1:OFS_W]);
  assign acc_rd   = win_hit && iord && !iowr;
  assign acc_wr   = win_hit && iowr && !iord;
  assign tgt      = (acc_rd || acc_wr) ? classify(ofs) : TGT_NONE;
  assign reg_sel  = ofs[2:0];
  assign word_cyc = (acc_rd || acc_wr) && (ofs == '0);

  // R1: a miss never yields an access
  a_r1_miss_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (!acc_rd && !acc_wr));
  // R13: both strobes together is no access
  a_r13_dual_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (iord && iowr) |-> (tgt == TGT_NONE));
  // R5: word cycles always point at the command block
  a_r5_word_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    word_cyc |-> (tgt == TGT_CMD && reg_sel == 3'd0));
endmodule

// File: rtl/ata8_hold_reg.sv
`timescale 1ns/1ps
module ata8_hold_reg #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_rd,
  input  logic          cap_wr,
  input  logic [BW-1:0] rd_byte,
  input  logic [BW-1:0] wr_byte,
  output logic [BW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (cap_wr) q <= wr_byte;
    else if (cap_rd) q <= rd_byte;
  end

  // R4: a host load lands on the next edge
  a_r4_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wr |=> (q == $past(wr_byte)));
  // R2: a word read capture lands on the next edge
  a_r2_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rd && !cap_wr) |=> (q == $past(rd_byte)));
  // R6: without a trigger the register holds
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_rd && !cap_wr) |=> $stable(q));
endmodule

// File: rtl/ata8_irq_route.sv
`timescale 1ns/1ps
module ata8_irq_route #(
  parameter int         LINES   = 8,
  parameter logic [7:0] ALLOWED = 8'b1011_1100,
  localparam int        SEL_W   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             req,
  output logic [LINES-1:0] lines
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    if (ALLOWED[n]) begin : g_on
      assign lines[n] = req && (sel == SEL_W'(n));
    end else begin : g_off
      assign lines[n] = 1'b0;
    end
  end

  // R9: at most one line, and only with a request
  a_r9_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lines));
  a_r9_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|lines) |-> req);
endmodule

// File: rtl/ata8_bridge.sv
`timescale 1ns/1ps
module ata8_bridge
  import ata8_bridge_pkg::*;
#(
  parameter int         IRQ_LINES   = 8,
  parameter logic [7:0] IRQ_ALLOWED = 8'b1011_1100,
  localparam int        IRQ_SEL_W   = $clog2(IRQ_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW_W-1:0]      io_sw,
  input  logic [SW_W-1:0]      rom_sw,
  input  logic [IRQ_SEL_W-1:0] irq_sel,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic                 iord,
  input  logic                 iowr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  input  logic [MEM_AW-1:0]    mem_addr,
  output logic                 rom_sel,
  output logic                 ata_cs0,
  output logic                 ata_cs1,
  output logic [2:0]           ata_addr,
  output logic                 ata_rd,
  output logic                 ata_wr,
  output logic                 ata_wide,
  output logic [15:0]          ata_wdata,
  input  logic [15:0]          ata_rdata,
  input  logic                 drive_irq,
  output logic [IRQ_LINES-1:0] host_irq
);
  // Settings captured during reset (R11)
  logic [SW_W-1:0]      io_sw_q, rom_sw_q;
  logic [IRQ_SEL_W-1:0] irq_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_sw_q   <= io_sw;
      rom_sw_q  <= rom_sw;
      irq_sel_q <= irq_sel;
    end
  end

  logic       acc_rd, acc_wr, word_cyc;
  tgt_e       tgt;
  logic [2:0] reg_sel;
  logic       hold_cap_rd, hold_cap_wr;
  logic [7:0] hold_q;
  logic [MEM_AW-1:0] rom_base;

  ata8_decode #(.AW(IO_AW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .iord     (iord),
    .iowr     (iowr),
    .win_base (io_window_base(io_sw_q)),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .tgt      (tgt),
    .reg_sel  (reg_sel),
    .word_cyc (word_cyc)
  );

  assign hold_cap_rd = acc_rd && word_cyc;
  assign hold_cap_wr = acc_wr && (tgt == TGT_HOLD);

  ata8_hold_reg #(.BW(8)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_rd  (hold_cap_rd),
    .cap_wr  (hold_cap_wr),
    .rd_byte (ata_rdata[15:8]),
    .wr_byte (host_wdata),
    .q       (hold_q)
  );

  assign ata_cs0   = (tgt == TGT_CMD);
  assign ata_cs1   = (tgt == TGT_CTL);
  assign ata_rd    = acc_rd && (ata_cs0 || ata_cs1);
  assign ata_wr    = acc_wr && (ata_cs0 || ata_cs1);
  assign ata_addr  = (ata_cs0 || ata_cs1) ? reg_sel : 3'd0;
  assign ata_wide  = word_cyc;
  assign ata_wdata = {(word_cyc && acc_wr) ? hold_q : 8'h00, host_wdata};

  always_comb begin
    host_rdata = 8'h00;
    if (acc_rd) begin
      if (tgt == TGT_HOLD) host_rdata = hold_q;
      else                 host_rdata = ata_rdata[7:0];
    end
  end

  assign rom_base = rom_window_base(rom_sw_q);
  assign rom_sel  = (mem_addr[MEM_AW-1:ROM_SPAN_W] == rom_base[MEM_AW-1:ROM_SPAN_W]);

  ata8_irq_route #(.LINES(IRQ_LINES), .ALLOWED(IRQ_ALLOWED)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (irq_sel_q),
    .req   (drive_irq),
    .lines (host_irq)
  );

  // R7: the two selects are exclusive
  a_r7_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ata_cs0 && ata_cs1));
  // R3: the holding-register port never strobes the drive
  a_r3_hold_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cap_wr || (acc_rd && tgt == TGT_HOLD)) |-> !(ata_rd || ata_wr));
  // R8: a word write carries the held byte
  a_r8_word_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_wr && ata_wide) |-> (ata_wdata[15:8] == hold_q));
endmodule

// File: tb/ata8_bridge_tb.sv
`timescale 1ns/1ps
module ata8_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  io_sw, rom_sw;
  logic [2:0]  irq_sel;
  logic [9:0]  io_addr;
  logic        iord, iowr;
  logic [7:0]  host_wdata, host_rdata;
  logic [19:0] mem_addr;
  logic        rom_sel, ata_cs0, ata_cs1, ata_rd, ata_wr, ata_wide;
  logic [2:0]  ata_addr;
  logic [15:0] ata_wdata, ata_rdata;
  logic        drive_irq;
  logic [7:0]  host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ata8_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .io_sw(io_sw), .rom_sw(rom_sw), .irq_sel(irq_sel),
    .io_addr(io_addr), .iord(iord), .iowr(iowr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .rom_sel(rom_sel),
    .ata_cs0(ata_cs0), .ata_cs1(ata_cs1), .ata_addr(ata_addr), .ata_rd(ata_rd),
    .ata_wr(ata_wr), .ata_wide(ata_wide), .ata_wdata(ata_wdata),
    .ata_rdata(ata_rdata), .drive_irq(drive_irq), .host_irq(host_irq)
  );

  // Row: req(4) addr(10) rd wr wdata(8) ardata(16) | cs0 cs1 addr(3) wide rd wr rdata(8) wdata(16)
  localparam int NV = 17;
  localparam logic [71:0] VEC [NV] = '{
    {4'd12, 10'h268, 2'b10, 8'h00, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
    {4'd4,  10'h268, 2'b01, 8'hA5, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00, 16'h00A5},
    {4'd3,  10'h268, 2'b10, 8'h00, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hA5, 16'h0000},
    {4'd5,  10'h260, 2'b01, 8'h3C, 16'h0000, 1'b1,1'b0,3'd0,1'b1,1'b0,1'b1, 8'h00, 16'hA53C},
    {4'd2,  10'h260, 2'b10, 8'h00, 16'hBEEF, 1'b1,1'b0,3'd0,1'b1,1'b1,1'b0, 8'hEF, 16'h0000},
    {4'd8,  10'h260, 2'b01, 8'h11, 16'h0000, 1'b1,1'b0,3'd0,1'b1,1'b0,1'b1, 8'h00, 16'hBE11},
    {4'd6,  10'h265, 2'b10, 8'h00, 16'h1234, 1'b1,1'b0,3'd5,1'b0,1'b1,1'b0, 8'h34, 16'h0000},
    {4'd6,  10'h267, 2'b01, 8'h9A, 16'h0000, 1'b1,1'b0,3'd7,1'b0,1'b0,1'b1, 8'h00, 16'h009A},
    {4'd7,  10'h26E, 2'b10, 8'h00, 16'h00F0, 1'b0,1'b1,3'd6,1'b0,1'b1,1'b0, 8'hF0, 16'h0000},
    {4'd7,  10'h269, 2'b01, 8'h55, 16'h0000, 1'b0,1'b1,3'd1,1'b0,1'b0,1'b1, 8'h00, 16'h0055},
    {4'd1,  10'h280, 2'b10, 8'h00, 16'hCAFE, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
    {4'd1,  10'h250, 2'b01, 8'h77, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00, 16'h0077},
    {4'd1,  10'h268, 2'b10, 8'h00, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hBE, 16'h0000},
    {4'd13, 10'h268, 2'b11, 8'h44, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'h00, 16'h0044},
    {4'd13, 10'h268, 2'b10, 8'h00, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hBE, 16'h0000},
    {4'd6,  10'h261, 2'b10, 8'h00, 16'hAB01, 1'b1,1'b0,3'd1,1'b0,1'b1,1'b0, 8'h01, 16'h0000},
    {4'd6,  10'h268, 2'b10, 8'h00, 16'h0000, 1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hBE, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] ios, input logic [3:0] roms, input logic [2:0] irs);
    @(negedge clk);
    rst_n = 1'b0; io_sw = ios; rom_sw = roms; irq_sel = irs;
    iord = 1'b0; iowr = 1'b0; drive_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] irq_expect(input logic [2:0] s, input logic r);
    case (s)
      3'd2, 3'd3, 3'd4, 3'd5, 3'd7: return r ? (8'h01 << s) : 8'h00;
      default:                      return 8'h00;
    endcase
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_sw = 4'd3; rom_sw = 4'd5; irq_sel = 3'd0;
    io_addr = '0; iord = 1'b0; iowr = 1'b0; host_wdata = '0;
    mem_addr = '0; ata_rdata = '0; drive_irq = 1'b0;
    do_reset(4'd3, 4'd5, 3'd4);

    // Reset state: idle outputs (R12)
    #2;
    check("R12 idle strobes", {29'd0, ata_cs0, ata_cs1, ata_rd || ata_wr}, 32'd0);

    // Vector table at I/O base 0x260 (R1 R2 R3 R4 R5 R6 R7 R8 R13)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {io_addr, iord, iowr, host_wdata, ata_rdata} = VEC[i][67:32];
      #2;
      check($sformatf("R%0d row %0d", VEC[i][71:68], i),
            {ata_cs0, ata_cs1, ata_addr, ata_wide, ata_rd, ata_wr, host_rdata, ata_wdata},
            VEC[i][31:0]);
    end
    @(negedge clk); iord = 1'b0; iowr = 1'b0;

    // R10: ROM window at 0xD4000..0xD5FFF for switch 5
    mem_addr = 20'hD4000; #1; check("R10 base", {31'd0, rom_sel}, 32'd1);
    mem_addr = 20'hD5FFF; #1; check("R10 top",  {31'd0, rom_sel}, 32'd1);
    mem_addr = 20'hD6000; #1; check("R10 above", {31'd0, rom_sel}, 32'd0);
    mem_addr = 20'hD3FFF; #1; check("R10 below", {31'd0, rom_sel}, 32'd0);

    // R9: every setting of the interrupt selector
    for (int s = 0; s < 8; s++) begin
      do_reset(4'd3, 4'd5, 3'(s));
      #2;
      drive_irq = 1'b1; #1;
      check($sformatf("R9 sel %0d asserted", s), {24'd0, host_irq}, {24'd0, irq_expect(3'(s), 1'b1)});
      drive_irq = 1'b0; #1;
      check($sformatf("R9 sel %0d idle", s), {24'd0, host_irq}, 32'd0);
    end

    // R11: switches changed after reset have no effect
    do_reset(4'd3, 4'd5, 3'd4);
    @(negedge clk);
    io_sw = 4'd0; rom_sw = 4'd0; irq_sel = 3'd7;
    drive_irq = 1'b1; #1;
    check("R11 irq setting held", {24'd0, host_irq}, 32'h10);
    drive_irq = 1'b0;
    mem_addr = 20'hD4000; #1;
    check("R11 rom switch held", {31'd0, rom_sel}, 32'd1);
    io_addr = 10'h261; iord = 1'b1; ata_rdata = 16'h0042; #1;
    check("R11 io switch held", {24'd0, host_rdata}, 32'h42);
    io_addr = 10'h201; #1;
    check("R11 new base ignored", {31'd0, ata_cs0}, 32'd0);
    @(negedge clk); iord = 1'b0;

    // R12: holding register cleared by a second reset
    do_reset(4'd3, 4'd5, 3'd4);
    @(negedge clk);
    io_addr = 10'h268; iord = 1'b1; #2;
    check("R12 hold cleared", {24'd0, host_rdata}, 32'd0);
    @(negedge clk); iord = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule